// File: doc/BRIEF.md
# Core Bus Status Encoder

This block takes transaction requests from a processor core and emits a 3-bit status code with each external bus cycle. The code tells an external observer whether the cycle opens a transaction (its first, or T1, cycle) and what kind of transaction it is. When the core is parked waiting for an interrupt, a dedicated code says so.

A word access aimed at a region of 8-bit memory cannot complete in one external cycle. The encoder therefore breaks it into two byte cycles, low byte first and high byte second. Only the first of the pair carries the transaction code. The second reports as a continuation cycle.

A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Status, strobe and byte-lane outputs are registered and appear in the following cycle. While the high half of a split access is still owed, `req_ready` stays low and the core must hold off. Reset is asserted asynchronously and released through a synchronizer, so `req_ready` rises only after the release has passed through it.

Top module: `bus_status_encoder`

## Requirements
- R1: While `rst_n` is low, `bus_stat` is 000, `ext_strobe` is 0, `ext_a0` is 0 and `req_ready` is 0. After `rst_n` rises, `req_ready` stays low for SYNC_STAGES clock edges.
- R2: A cycle with no external cycle issued and `wfi` low at the preceding edge shows `bus_stat` = 000 and `ext_strobe` = 0.
- R3: A cycle with no external cycle issued and `wfi` high at the preceding edge shows `bus_stat` = 001 and `ext_strobe` = 0. This repeats on every such cycle.
- R4: An accepted request produces `ext_strobe` = 1 in the next cycle. Its status code depends on `req_kind`: 0 (interrupt acknowledge) gives 010, 1 (data move by another bus master) gives 011, 2 (sequential fetch) gives 100, 3 (non-sequential fetch) gives 101, 4 (core data) gives 110, and 5 (exception data) gives 111.
- R5: A byte request (`req_word` = 0) or a word request to a wide region (`req_narrow` = 0) produces exactly one strobe cycle. `ext_a0` equals `req_a0` for a byte request and 0 for a word request.
- R6: A word request to a narrow region (`req_word` = 1, `req_narrow` = 1) produces two consecutive strobe cycles. The first carries the R4 code with `ext_a0` = 0. The second carries 000 with `ext_a0` = 1.
- R7: `req_ready` is low during the first cycle of a split pair. A `req_valid` presented while `req_ready` is low is ignored and produces no strobe.
- R8: The reserved `req_kind` values 6 and 7 still produce a strobe cycle, reported with code 000.
- R9: An accepted request takes precedence over `wfi`. The second cycle of a split pair reports 000 even when `wfi` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a transaction |
| req_ready | output | 1 | Encoder can accept a transaction this cycle |
| req_kind | input | 3 | Transaction type (see R4, R8) |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_narrow | input | 1 | Target region is 8-bit memory |
| req_a0 | input | 1 | Byte address bit 0 for byte accesses |
| wfi | input | 1 | Core is waiting for an interrupt |
| bus_stat | output | 3 | Status code of the current external cycle |
| ext_strobe | output | 1 | An external bus cycle is in progress |
| ext_a0 | output | 1 | Byte lane of the current external cycle |

## Verification
On every cycle, the assertions check the code mapping for each accepted kind, the two-cycle shape of a split access with its back-pressure, the byte-lane choice, and the rule that strobe-free cycles show only 000 or 001. The hold of 001 while waiting is checked as well. The reset values and the delay that the reset synchronizer adds before the first acceptance can only be shown by the bench. The same applies to the interplay of `wfi` with back-to-back and stalled requests: the bench drives a directed sweep of every kind, size and region combination, then a long random run, and compares against its reference model.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int KIND_W = 3;
  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_CONT  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_INTA  = 3'd2,
    ST_XMST  = 3'd3,
    ST_SEQF  = 3'd4,
    ST_JMPF  = 3'd5,
    ST_CDAT  = 3'd6,
    ST_EXCD  = 3'd7
  } stat_e;

  typedef enum logic [KIND_W-1:0] {
    K_INTA = 3'd0,
    K_XMST = 3'd1,
    K_SEQF = 3'd2,
    K_JMPF = 3'd3,
    K_CDAT = 3'd4,
    K_EXCD = 3'd5
  } kind_e;

  typedef struct packed {
    stat_e stat;
    logic  strobe;
    logic  a0;
  } cyc_t;
endpackage

// File: rtl/bse_rst_sync.sv
module bse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bse_code_map.sv
module bse_code_map
  import bse_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output stat_e             code
);
  always_comb begin
    case (kind)
      K_INTA:  code = ST_INTA;
      K_XMST:  code = ST_XMST;
      K_SEQF:  code = ST_SEQF;
      K_JMPF:  code = ST_JMPF;
      K_CDAT:  code = ST_CDAT;
      K_EXCD:  code = ST_EXCD;
      default: code = ST_CONT;
    endcase
  end
endmodule

// File: rtl/bse_split_ctrl.sv
module bse_split_ctrl (
  input  logic clk,
  input  logic srst_n,
  input  logic accept,
  input  logic split,
  output logic hi_owed
);
  logic hi_owed_d;
  logic hi_en;

  always_comb begin
    hi_en     = hi_owed | accept;
    hi_owed_d = hi_owed ? 1'b0 : (accept & split);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    hi_owed <= 1'b0;
    else if (hi_en) hi_owed <= hi_owed_d;
  end
endmodule

// File: rtl/bse_out_stage.sv
module bse_out_stage
  import bse_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  hi_owed,
  input  logic  accept,
  input  stat_e code,
  input  logic  lane,
  input  logic  wfi,
  output stat_e bus_stat,
  output logic  ext_strobe,
  output logic  ext_a0
);
  cyc_t cyc_d;
  cyc_t cyc_q;

  always_comb begin
    if (hi_owed) begin
      cyc_d.stat   = ST_CONT;
      cyc_d.strobe = 1'b1;
      cyc_d.a0     = 1'b1;
    end else if (accept) begin
      cyc_d.stat   = code;
      cyc_d.strobe = 1'b1;
      cyc_d.a0     = lane;
    end else begin
      cyc_d.stat   = wfi ? ST_WAIT : ST_CONT;
      cyc_d.strobe = 1'b0;
      cyc_d.a0     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cyc_q <= '{stat: ST_CONT, strobe: 1'b0, a0: 1'b0};
    else         cyc_q <= cyc_d;
  end

  assign bus_stat   = cyc_q.stat;
  assign ext_strobe = cyc_q.strobe;
  assign ext_a0     = cyc_q.a0;
endmodule

// File: rtl/bus_status_encoder.sv
module bus_status_encoder
  import bse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_word,
  input  logic              req_narrow,
  input  logic              req_a0,
  input  logic              wfi,
  output logic [STAT_W-1:0] bus_stat,
  output logic              ext_strobe,
  output logic              ext_a0
);
  logic  srst_n;
  logic  hi_owed;
  logic  accept;
  logic  split;
  logic  lane;
  stat_e code;
  stat_e stat_q;

  bse_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign req_ready = srst_n & ~hi_owed;
  assign accept    = req_valid & req_ready;
  assign split     = req_word & req_narrow;
  assign lane      = req_word ? 1'b0 : req_a0;

  bse_code_map u_map (
    .kind (req_kind),
    .code (code)
  );

  bse_split_ctrl u_split (
    .clk     (clk),
    .srst_n  (srst_n),
    .accept  (accept),
    .split   (split),
    .hi_owed (hi_owed)
  );

  bse_out_stage u_out (
    .clk        (clk),
    .srst_n     (srst_n),
    .hi_owed    (hi_owed),
    .accept     (accept),
    .code       (code),
    .lane       (lane),
    .wfi        (wfi),
    .bus_stat   (stat_q),
    .ext_strobe (ext_strobe),
    .ext_a0     (ext_a0)
  );

  assign bus_stat = stat_q;
endmodule

// File: rtl/bse_checker.sv
module bse_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_kind,
  input logic       req_word,
  input logic       req_narrow,
  input logic       req_a0,
  input logic       wfi,
  input logic [2:0] bus_stat,
  input logic       ext_strobe,
  input logic       ext_a0
);
  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_strobe |-> (bus_stat == 3'd0 || bus_stat == 3'd1)); // R2

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && wfi) |=> (bus_stat == 3'd1 && !ext_strobe)); // R3

  AST_KIND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind < 3'd6) |=>
      (ext_strobe && bus_stat == 3'($past(req_kind) + 3'd2))); // R4

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_word) |=> (ext_strobe && ext_a0 == $past(req_a0))); // R5

  AST_SPLIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_word && req_narrow) |=>
      (ext_strobe && !ext_a0 && !req_ready) ##1 (ext_strobe && ext_a0 && bus_stat == 3'd0)); // R6

  AST_STALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && ext_strobe && !ext_a0) |=> (ext_strobe && ext_a0)); // R7

  AST_RESERVED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind >= 3'd6) |=> (ext_strobe && bus_stat == 3'd0)); // R8
endmodule

bind bus_status_encoder bse_checker i_bse_checker (.*);

// File: tb/test_bus_status_encoder.sv
module test_bus_status_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int WATCHDOG = 200000;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [2:0] req_kind;
  logic       req_word;
  logic       req_narrow;
  logic       req_a0;
  logic       wfi;
  logic [2:0] bus_stat;
  logic       ext_strobe;
  logic       ext_a0;

  bus_status_encoder #(.SYNC_STAGES(SYNC)) i_bus_status_encoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_word(req_word), .req_narrow(req_narrow),
    .req_a0(req_a0), .wfi(wfi), .bus_stat(bus_stat),
    .ext_strobe(ext_strobe), .ext_a0(ext_a0)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int         since_rel;
  logic [2:0] e_stat;
  logic       e_stb, e_a0, e_rdy;
  string      e_tag;
  int         owed_q[$];

  initial begin
    since_rel = 0; e_stat = 3'd0; e_stb = 0; e_a0 = 0; e_rdy = 0; e_tag = "R1";
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      since_rel = 0; e_stat = 3'd0; e_stb = 0; e_a0 = 0; e_rdy = 0; e_tag = "R1";
      owed_q.delete();
    end else begin
      if (since_rel < SYNC) begin
        e_stat = 3'd0; e_stb = 0; e_a0 = 0; e_tag = "R1";
      end else if (owed_q.size() > 0) begin
        void'(owed_q.pop_front());
        e_stat = 3'd0; e_stb = 1; e_a0 = 1; e_tag = wfi ? "R9" : "R6";
      end else if (req_valid && e_rdy) begin
        e_stb  = 1;
        e_stat = (req_kind <= 3'd5) ? 3'(req_kind + 3'd2) : 3'd0;
        e_tag  = (req_kind <= 3'd5) ? "R4" : "R8";
        if (req_word && req_narrow) begin
          e_a0 = 0; owed_q.push_back(1); e_tag = "R6";
        end else begin
          e_a0 = req_word ? 1'b0 : req_a0;
          if (e_tag == "R4") e_tag = "R5";
        end
      end else begin
        e_stb = 0; e_a0 = 0;
        e_stat = wfi ? 3'd1 : 3'd0;
        e_tag = wfi ? "R3" : "R2";
      end
      if (since_rel < SYNC) since_rel++;
      e_rdy = (since_rel >= SYNC) && (owed_q.size() == 0);
      if (!e_rdy && since_rel >= SYNC) e_tag = {e_tag, "/R7"};
    end
  end

  task automatic check_outputs();
    n_checks++;
    if (bus_stat !== e_stat || ext_strobe !== e_stb || ext_a0 !== e_a0 || req_ready !== e_rdy) begin
      n_fails++;
      $display("FAIL %s: stat/strobe/a0/ready actual %b/%b/%b/%b expected %b/%b/%b/%b at %0t",
               e_tag, bus_stat, ext_strobe, ext_a0, req_ready, e_stat, e_stb, e_a0, e_rdy, $time);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] k, input logic w,
                      input logic n, input logic a, input logic wt);
    @(negedge clk);
    check_outputs();
    req_valid = v; req_kind = k; req_word = w; req_narrow = n; req_a0 = a; wfi = wt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_word = 0; req_narrow = 0; req_a0 = 0; wfi = 0;
    // R1: reset values, including wfi and valid pressure
    repeat (3) step(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1;
    // R1: ready delayed by synchronizer, R2 idle
    repeat (4) step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: wait code held
    repeat (5) step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4 R5 R6 R8: every kind, size, region, lane
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 8; m++) begin
        step(1'b1, 3'(k), m[0], m[1], m[2], 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      end
    // R7 R9: valid held high through split pairs with wfi high
    repeat (12) step(1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (6) step(1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 5000; i++)
      step(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    repeat (3) step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_outputs();
    finish_run();
  end
endmodule